// File: doc/BRIEF.md
# Weighted-Round Queue Scheduler

This block decides which of a port's output queues (eight by default) may send its next packet. Each queue has a configuration entry written through a simple write strobe. The entry holds a weight from 0 to 8, a strict-priority flag, a flag marking the top queue of the strict-priority group, and a flag marking the end of the port's queue list. Every cycle in which `sel_req` is high, the block looks at the per-queue `q_ready` lines and the stored configuration. In the next cycle it presents a one-hot `gnt_q` together with `gnt_vld`.

Strict-priority queues are always served first, lowest index first. When no strict-priority queue is ready, the remaining queues share the port over a cycle of eight rounds. Each weight becomes an 8-bit participation mask whose set bits are spread across the rounds, so a queue sends in as many rounds as its weight. Within a round, each participating queue sends at most once, in round-robin order. If the strict-priority flags do not form a valid group, the block raises `cfg_err` and treats every queue as weighted.

Top module: `wrs_sched`

## Requirements
- R1: After reset, `gnt_vld` is 0, `gnt_q` is 0 and `cfg_err` is 0. Every stored weight is 0 and no flag is set, so no request is granted until a queue is configured.
- R2: A grant shows up on `gnt_q`/`gnt_vld` in the cycle after the one in which `sel_req` was high. When `sel_req` is low, `gnt_vld` is 0 in the next cycle and the round state does not move.
- R3: Weight w sets the queue's round mask as follows: 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f, 8→0xff. Any weight from 9 to 15 gives 0xff. A weighted queue may be granted in round r only when bit r of its mask is 1.
- R4: Within a round, each eligible weighted queue is granted at most once, in ascending index order. The search starts after the last granted weighted queue and wraps. After reset the round is 0 and queue 0 is searched first. When no eligible queue is left in the current round, the round steps forward (7 wraps to 0) to the next round that has a ready participant.
- R5: A weighted queue with mask 0x00 is never granted.
- R6: While any valid strict-priority queue is ready, the lowest-index ready one is granted. Such grants leave the weighted round, pointer and served state unchanged.
- R7: The strict-priority flags must cover queues 0..k with no gaps, and the group-top flag must be set exactly on queue k. With no strict queues, no group-top flag may be set. Any other setting drives `cfg_err` to 1 and makes every queue weighted with its own mask.
- R8: The lowest-index queue whose list-end flag is set is the last queue of the port, and higher queues are never granted. With no list-end flag set, all queues belong to the port.
- R9: If no queue is eligible in any round, `gnt_vld` stays 0 and the scheduler state is unchanged.
- R10: A configuration write takes effect from the next cycle on and may be made while grants are flowing. The write stores `cfg_weight`, `cfg_static`, `cfg_grp_top` and `cfg_list_end` for queue `cfg_qid`.
- R11: A queue whose `q_ready` bit is 0 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_ready | input | NQ | Per-queue has-work flags |
| sel_req | input | 1 | Request for one grant decision |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | QW | Queue written by the strobe |
| cfg_weight | input | 4 | Weight 0..8 (9..15 act as 8) |
| cfg_static | input | 1 | Strict-priority flag |
| cfg_grp_top | input | 1 | Top-of-strict-group flag |
| cfg_list_end | input | 1 | End-of-port-list flag |
| gnt_q | output | NQ | One-hot grant |
| gnt_vld | output | 1 | Grant valid |
| cfg_err | output | 1 | Strict-priority group setting is invalid |

## Verification
The bench builds the block with its default values: eight queues and the fixed eight-round mask. This makes every weight mask, the 7→0 round wrap and a full eight-queue list (no list-end flag) reachable with short directed runs. With two active queues, one at weight 8 and one at the weight under test, the whole grant sequence follows directly from the mask table. That lets every weight, including the over-range codes, be checked across a complete round cycle and the first round after it.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int ROUNDS = 8;
  localparam int RW     = 3;
  localparam int WW     = 4;

  function automatic logic [ROUNDS-1:0] weight_to_mask(input logic [WW-1:0] w);
    logic [ROUNDS-1:0] m;
    case (w)
      4'd0:    m = 8'h00;
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h11;
      4'd3:    m = 8'h49;
      4'd4:    m = 8'h55;
      4'd5:    m = 8'h57;
      4'd6:    m = 8'h77;
      4'd7:    m = 8'h7f;
      default: m = 8'hff;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wrs_cfg_bank.sv
module wrs_cfg_bank
  import wrs_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [QW-1:0]               qid,
  input  logic [WW-1:0]               weight,
  input  logic                        stat,
  input  logic                        grp_top,
  input  logic                        list_end,
  output logic [NQ-1:0][ROUNDS-1:0]   mask_v,
  output logic [NQ-1:0]               stat_v,
  output logic [NQ-1:0]               top_v,
  output logic [NQ-1:0]               end_v
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic wr_en;
    assign wr_en = we && (qid == QW'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_v[q] <= '0;
        stat_v[q] <= 1'b0;
        top_v[q]  <= 1'b0;
        end_v[q]  <= 1'b0;
      end else if (wr_en) begin
        mask_v[q] <= weight_to_mask(weight);
        stat_v[q] <= stat;
        top_v[q]  <= grp_top;
        end_v[q]  <= list_end;
      end
    end
  end
endmodule

// File: rtl/wrs_cfg_check.sv
module wrs_cfg_check #(
  parameter int NQ = 8
) (
  input  logic [NQ-1:0] stat_v,
  input  logic [NQ-1:0] top_v,
  input  logic [NQ-1:0] end_v,
  output logic [NQ-1:0] act_v,
  output logic [NQ-1:0] stat_eff,
  output logic [NQ-1:0] wgt_v,
  output logic          err
);
  logic [NQ-1:0] stat_top;
  logic          gap_bad;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      act_v[q] = ~seen;
      if (end_v[q]) seen = 1'b1;
    end
  end

  assign gap_bad  = (stat_v & (stat_v + NQ'(1))) != '0;
  assign stat_top = stat_v & ~(stat_v >> 1);
  assign err      = gap_bad || (top_v != stat_top);
  assign stat_eff = err ? '0 : (stat_v & act_v);
  assign wgt_v    = act_v & ~stat_eff;
endmodule

// File: rtl/wrs_rr_pick.sv
module wrs_rr_pick #(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] cand,
  input  logic [QW-1:0] ptr,
  output logic [NQ-1:0] pick,
  output logic [QW-1:0] pick_idx
);
  always_comb begin
    logic found;
    int   idx;
    found    = 1'b0;
    pick     = '0;
    pick_idx = '0;
    for (int i = 1; i <= NQ; i++) begin
      idx = (int'(ptr) + i) % NQ;
      if (!found && cand[idx]) begin
        found     = 1'b1;
        pick[idx] = 1'b1;
        pick_idx  = QW'(idx);
      end
    end
  end
endmodule

// File: rtl/wrs_sched.sv
module wrs_sched
  import wrs_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] q_ready,
  input  logic          sel_req,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_qid,
  input  logic [WW-1:0] cfg_weight,
  input  logic          cfg_static,
  input  logic          cfg_grp_top,
  input  logic          cfg_list_end,
  output logic [NQ-1:0] gnt_q,
  output logic          gnt_vld,
  output logic          cfg_err
);
  // reset synchronizer: assert asynchronously, release on clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NQ-1:0][ROUNDS-1:0] mask_v;
  logic [NQ-1:0] stat_v, top_v, end_v;
  logic [NQ-1:0] act_v, stat_eff, wgt_v;

  wrs_cfg_bank #(.NQ(NQ)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .qid(cfg_qid),
    .weight(cfg_weight), .stat(cfg_static), .grp_top(cfg_grp_top),
    .list_end(cfg_list_end), .mask_v(mask_v), .stat_v(stat_v),
    .top_v(top_v), .end_v(end_v)
  );

  wrs_cfg_check #(.NQ(NQ)) u_check (
    .stat_v(stat_v), .top_v(top_v), .end_v(end_v), .act_v(act_v),
    .stat_eff(stat_eff), .wgt_v(wgt_v), .err(cfg_err)
  );

  // scheduler state
  logic [RW-1:0] rnd_q, rnd_n;
  logic [NQ-1:0] served_q, served_n;
  logic [QW-1:0] ptr_q, ptr_n;
  logic [NQ-1:0] gnt_n;
  logic          vld_n;

  // strict-priority path: lowest ready member
  logic [NQ-1:0] stat_rdy, s_pick;
  assign stat_rdy = q_ready & stat_eff;
  assign s_pick   = stat_rdy & (~stat_rdy + NQ'(1));

  // round columns: queues taking part in each round
  logic [ROUNDS-1:0][NQ-1:0] col;
  always_comb begin
    for (int r = 0; r < ROUNDS; r++)
      for (int q = 0; q < NQ; q++)
        col[r][q] = mask_v[q][r];
  end

  // find the nearest round (current first, then forward) with a candidate
  logic [NQ-1:0] w_cand;
  logic [RW:0]   d_sel;
  logic          w_any;
  always_comb begin
    logic [NQ-1:0] c;
    int            r;
    w_any  = 1'b0;
    w_cand = '0;
    d_sel  = '0;
    for (int d = 0; d <= ROUNDS; d++) begin
      r = (int'(rnd_q) + d) % ROUNDS;
      c = q_ready & wgt_v & col[r];
      if (d == 0) c = c & ~served_q;
      if (!w_any && (c != '0)) begin
        w_any  = 1'b1;
        w_cand = c;
        d_sel  = (RW+1)'(d);
      end
    end
  end

  logic [NQ-1:0] w_pick;
  logic [QW-1:0] w_idx;
  wrs_rr_pick #(.NQ(NQ)) u_rr (
    .cand(w_cand), .ptr(ptr_q), .pick(w_pick), .pick_idx(w_idx)
  );

  logic          st_en;
  logic [RW:0]   rnd_sum;
  assign st_en   = sel_req && (stat_rdy == '0) && w_any;
  assign rnd_sum = {1'b0, rnd_q} + d_sel;

  always_comb begin
    gnt_n    = '0;
    vld_n    = 1'b0;
    rnd_n    = rnd_q;
    served_n = served_q;
    ptr_n    = ptr_q;
    if (sel_req) begin
      if (stat_rdy != '0) begin
        gnt_n = s_pick;
        vld_n = 1'b1;
      end else if (w_any) begin
        gnt_n    = w_pick;
        vld_n    = 1'b1;
        rnd_n    = rnd_sum[RW-1:0];
        served_n = ((d_sel != '0) ? '0 : served_q) | w_pick;
        ptr_n    = w_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gnt_q   <= '0;
      gnt_vld <= 1'b0;
    end else begin
      gnt_q   <= gnt_n;
      gnt_vld <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rnd_q    <= '0;
      served_q <= '0;
      ptr_q    <= QW'(NQ-1);
    end else if (st_en) begin
      rnd_q    <= rnd_n;
      served_q <= served_n;
      ptr_q    <= ptr_n;
    end
  end
endmodule

// File: rtl/wrs_sched_chk.sv
module wrs_sched_chk
  import wrs_pkg::*;
#(
  parameter int NQ = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sel_req,
  input logic [NQ-1:0]             q_ready,
  input logic [NQ-1:0]             gnt_q,
  input logic                      gnt_vld,
  input logic                      cfg_err,
  input logic [NQ-1:0]             stat_eff,
  input logic [NQ-1:0]             wgt_v,
  input logic [NQ-1:0][ROUNDS-1:0] mask_v,
  input logic [RW-1:0]             rnd_q,
  input logic [NQ-1:0]             served_q
);
  logic [NQ-1:0] zero_w;
  always_comb begin
    for (int q = 0; q < NQ; q++) zero_w[q] = wgt_v[q] && (mask_v[q] == '0);
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> $onehot(gnt_q));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (gnt_q == '0));
  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> $past(sel_req));
  a_r2_no_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> ($stable(rnd_q) && $stable(served_q)));
  a_r11_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((gnt_q & $past(q_ready)) != '0));
  a_r5_zero_mask_never: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((gnt_q & $past(zero_w)) == '0));
  a_r6_strict_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && $past((q_ready & stat_eff) != '0)) |->
      (((gnt_q & $past(stat_eff)) != '0) &&
       (((gnt_q - NQ'(1)) & $past(q_ready & stat_eff)) == '0)));
  a_r7_err_no_strict: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (stat_eff == '0));
endmodule

bind wrs_sched wrs_sched_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .q_ready(q_ready),
  .gnt_q(gnt_q), .gnt_vld(gnt_vld), .cfg_err(cfg_err),
  .stat_eff(stat_eff), .wgt_v(wgt_v), .mask_v(mask_v),
  .rnd_q(rnd_q), .served_q(served_q)
);

// File: tb/wrs_sched_test.sv
module wrs_sched_test;
  localparam int NQ = 8;
  localparam int QW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NQ-1:0] q_ready;
  logic          sel_req;
  logic          cfg_we;
  logic [QW-1:0] cfg_qid;
  logic [3:0]    cfg_weight;
  logic          cfg_static, cfg_grp_top, cfg_list_end;
  logic [NQ-1:0] gnt_q;
  logic          gnt_vld;
  logic          cfg_err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  wrs_sched #(.NQ(NQ)) uut (
    .clk(clk), .rst_n(rst_n), .q_ready(q_ready), .sel_req(sel_req),
    .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_weight(cfg_weight),
    .cfg_static(cfg_static), .cfg_grp_top(cfg_grp_top),
    .cfg_list_end(cfg_list_end), .gnt_q(gnt_q), .gnt_vld(gnt_vld),
    .cfg_err(cfg_err)
  );

  function automatic logic [7:0] exp_mask(input int w);
    case (w)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h11; 3: return 8'h49;
      4: return 8'h55; 5: return 8'h57; 6: return 8'h77; 7: return 8'h7f;
      default: return 8'hff;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    sel_req = 1'b0; cfg_we = 1'b0; q_ready = '0;
    cfg_qid = '0; cfg_weight = '0; cfg_static = 1'b0;
    cfg_grp_top = 1'b0; cfg_list_end = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input int q, input int w, input bit st, input bit top, input bit le);
    cfg_we = 1'b1; cfg_qid = QW'(q); cfg_weight = 4'(w);
    cfg_static = st; cfg_grp_top = top; cfg_list_end = le;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one request; expect queue q granted (q<0: no grant)
  task automatic req_exp(input int q, input string tag);
    logic [NQ-1:0] e;
    sel_req = 1'b1;
    @(negedge clk);
    sel_req = 1'b0;
    e = (q < 0) ? '0 : (NQ'(1) << q);
    check((gnt_q == e) && (gnt_vld == (q >= 0)), tag, "grant",
          {gnt_vld, gnt_q}, {(q >= 0), e});
  endtask

  task automatic t_reset();
    do_reset();
    check(gnt_vld == 1'b0 && gnt_q == '0, "R1", "reset outputs", {gnt_vld, gnt_q}, 0);
    check(cfg_err == 1'b0, "R1", "reset cfg_err", cfg_err, 0);
    q_ready = '1;
    req_exp(-1, "R1");
  endtask

  // R3/R4/R5: queue0 at weight w, queue1 at weight 8
  task automatic t_weight(input int w);
    logic [7:0] m;
    do_reset();
    wr(0, w, 0, 0, 0);
    wr(1, 8, 0, 0, 1);
    q_ready = 8'h03;
    m = exp_mask(w);
    for (int r = 0; r < 8; r++) begin
      if (m[r]) req_exp(0, (w == 0) ? "R5" : "R3");
      req_exp(1, "R4");
    end
    req_exp(m[0] ? 0 : 1, "R4");
  endtask

  task automatic t_no_req_and_runtime();
    do_reset();
    wr(0, 8, 0, 0, 0);
    wr(1, 8, 0, 0, 1);
    q_ready = 8'h03;
    req_exp(0, "R4");
    repeat (3) begin
      @(negedge clk);
      check(gnt_vld == 1'b0, "R2", "no request", gnt_vld, 0);
    end
    req_exp(1, "R2");
    wr(0, 0, 0, 0, 0);
    req_exp(1, "R10");
    req_exp(1, "R10");
    wr(0, 8, 0, 0, 0);
    req_exp(0, "R10");
  endtask

  task automatic t_ready();
    do_reset();
    wr(0, 8, 0, 0, 0);
    wr(1, 8, 0, 0, 1);
    q_ready = 8'h02;
    req_exp(1, "R11");
    req_exp(1, "R11");
    q_ready = 8'h00;
    req_exp(-1, "R9");
    req_exp(-1, "R9");
    q_ready = 8'h03;
    req_exp(0, "R9");
  endtask

  task automatic t_static();
    do_reset();
    wr(0, 0, 1, 0, 0);
    wr(1, 0, 1, 1, 0);
    wr(2, 8, 0, 0, 0);
    wr(3, 8, 0, 0, 1);
    check(cfg_err == 1'b0, "R7", "valid group", cfg_err, 0);
    q_ready = 8'h0f;
    req_exp(0, "R6");
    req_exp(0, "R6");
    q_ready = 8'h0e;
    req_exp(1, "R6");
    q_ready = 8'h0c;
    req_exp(2, "R6");
    req_exp(3, "R4");
    req_exp(2, "R4");
  endtask

  task automatic t_bad_group();
    do_reset();
    wr(0, 8, 0, 0, 0);
    wr(1, 1, 1, 1, 1);
    check(cfg_err == 1'b1, "R7", "gap group", cfg_err, 1);
    q_ready = 8'h03;
    req_exp(0, "R7");
    req_exp(1, "R7");
    req_exp(0, "R7");
    req_exp(0, "R7");
    do_reset();
    wr(0, 8, 1, 0, 0);
    wr(1, 8, 0, 1, 1);
    check(cfg_err == 1'b1, "R7", "misplaced top", cfg_err, 1);
    wr(1, 8, 0, 0, 1);
    wr(0, 8, 1, 1, 0);
    check(cfg_err == 1'b0, "R7", "fixed group", cfg_err, 0);
  endtask

  task automatic t_list_end();
    do_reset();
    wr(1, 0, 0, 0, 1);
    wr(2, 8, 0, 0, 0);
    q_ready = 8'h04;
    req_exp(-1, "R8");
    wr(1, 0, 0, 0, 0);
    wr(2, 8, 0, 0, 1);
    req_exp(2, "R8");
    do_reset();
    wr(7, 8, 0, 0, 0);
    q_ready = 8'h80;
    req_exp(7, "R8");
  endtask

  initial begin
    t_reset();
    for (int w = 0; w <= 9; w++) t_weight(w);
    t_weight(15);
    t_no_req_and_runtime();
    t_ready();
    t_static();
    t_bad_group();
    t_list_end();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule